// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts the next fetch address in an instruction fetch unit. It keeps a tagged table, organised like a four-way cache of 64 sets (256 entries), in which each entry records a branch seen before: a valid bit, an address tag, the branch's last taken target and a two-bit saturating direction counter. Every cycle the fetch PC is looked up. The fetch is redirected to the stored target only when a matching entry predicts taken. Otherwise, whether the lookup missed or hit a not-taken counter, the block hands back the sequential address (fetch PC plus 4). A miss also raises no prediction flag.

When a branch resolves further down the pipe, its PC, actual direction and actual target are presented on the update port. A matching entry has its counter moved and its target refreshed. A branch that is missing and was taken claims a way of its set, picked by least-recently-updated replacement. In the same cycle the block classifies the resolution into one of four penalty cases, so that the pipeline can charge the right number of bubbles.

Top module: `btbPredictor`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until an update has allocated an entry.
- R2: On a lookup miss, predHit and predTaken are 0 and nextPc equals fetchPc + 4.
- R3: On a lookup hit whose counter is 2 or 3, predHit and predTaken are 1 and nextPc is the stored target.
- R4: On a lookup hit whose counter is 0 or 1, predHit is 1, predTaken is 0 and nextPc equals fetchPc + 4.
- R5: The set index is PC bits [7:2] and the tag is PC bits [31:8]. Up to four branches with the same index and different tags are held at once, and a lookup hits at most one way.
- R6: An update that misses allocates an entry only when the branch was taken, and the new counter is 2 (weakly taken). An update that misses and was not taken changes no entry.
- R7: An update that hits moves the counter up by one on taken and down by one on not-taken, saturating at 3 and at 0. It replaces the stored target only when the branch was taken.
- R8: Allocation uses the lowest-numbered invalid way of the set. When the set is full it uses the way updated least recently. Both a hitting update and an allocation make that way the most recent.
- R9: While updValid is 1, resCase reports 0 when the entry hit and its direction (counter of 2 or more) matched the outcome, 1 when the entry hit and its direction was wrong, 2 on a miss with a not-taken outcome, and 3 on a miss with a taken outcome.
- R10: A lookup and an update in the same cycle both see the table as it stood before that cycle's update. The update takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | 32 | Address being fetched this cycle |
| predHit | output | 1 | A matching entry exists for fetchPc |
| predTaken | output | 1 | The matching entry predicts taken |
| nextPc | output | 32 | Predicted next fetch address |
| updValid | input | 1 | A branch resolution is presented |
| updPc | input | 32 | PC of the resolved branch |
| updTaken | input | 1 | Actual direction of the resolved branch |
| updTarget | input | 32 | Actual target of the resolved branch |
| resCase | output | 2 | Penalty case of the resolution (R9 encoding) |

## Verification
If a counter is corrupted, the next lookup of that branch shows it within one cycle: predTaken is wrong and nextPc falls back to the sequential address, or the other way round. resCase on the next resolution of that branch also disagrees. Corrupted recency state shows up later and only indirectly, when a set fills. The wrong branch is then evicted, and the damage appears as a miss on a branch that should still hit, possibly many updates afterwards. Long random runs on a few crowded sets are therefore used alongside directed eviction cases.

// File: rtl/btbPkg.sv
package btbPkg;

  // counter width and the state given to a freshly allocated entry
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_WEAK_TAKEN = 2'b10;
  localparam logic [CTR_W-1:0] CTR_MAX = 2'b11;

  // wide enough for any supported way count
  localparam int WAY_FIELD_W = 8;

  typedef enum logic [1:0] {
    CASE_PRED_OK  = 2'd0,
    CASE_PRED_BAD = 2'd1,
    CASE_DFLT_OK  = 2'd2,
    CASE_DFLT_BAD = 2'd3
  } resCase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                   wrEn;
    logic                   alloc;
    logic                   setTarget;
    logic [WAY_FIELD_W-1:0] way;
    logic [CTR_W-1:0]       ctrNew;
  } btbStrobe_t;

endpackage

// File: rtl/btbDatapath.sv
module btbDatapath
  import btbPkg::*;
#(
  parameter int PC_W    = 32,
  parameter int WAYS    = 4,
  parameter int SETS    = 64,
  parameter int IDX_LSB = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  updPc,
  input  logic [PC_W-1:0]  updTarget,
  input  btbStrobe_t       strb,
  output logic             lookHit,
  output logic [CTR_W-1:0] lookCtr,
  output logic [PC_W-1:0]  lookTarget,
  output logic [WAYS-1:0]  updHitVec,
  output logic [CTR_W-1:0] updHitCtr,
  output logic [WAYS-1:0]  updValidVec
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_LSB - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic             validQ  [SETS][WAYS];
  logic [TAG_W-1:0] tagQ    [SETS][WAYS];
  logic [PC_W-1:0]  targetQ [SETS][WAYS];
  logic [CTR_W-1:0] ctrQ    [SETS][WAYS];

  logic [IDX_W-1:0] lookIdx, updIdx;
  logic [TAG_W-1:0] lookTag, updTag;
  logic [WAYS-1:0]  lookHitVec;
  logic [WAY_W-1:0] wrWay;

  assign lookIdx = fetchPc[IDX_LSB +: IDX_W];
  assign lookTag = fetchPc[PC_W-1 -: TAG_W];
  assign updIdx  = updPc[IDX_LSB +: IDX_W];
  assign updTag  = updPc[PC_W-1 -: TAG_W];
  assign wrWay   = strb.way[WAY_W-1:0];

  // parallel tag compare, one comparator pair per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lookHitVec[w]  = validQ[lookIdx][w] && (tagQ[lookIdx][w] == lookTag);
    assign updHitVec[w]   = validQ[updIdx][w] && (tagQ[updIdx][w] == updTag);
    assign updValidVec[w] = validQ[updIdx][w];
  end

  // AND-OR select of the hitting way's payload
  always_comb begin
    lookCtr    = '0;
    lookTarget = '0;
    updHitCtr  = '0;
    for (int w = 0; w < WAYS; w++) begin
      lookCtr    |= lookHitVec[w] ? ctrQ[lookIdx][w]    : '0;
      lookTarget |= lookHitVec[w] ? targetQ[lookIdx][w] : '0;
      updHitCtr  |= updHitVec[w]  ? ctrQ[updIdx][w]     : '0;
    end
  end

  assign lookHit = |lookHitVec;

  // only valid bits are reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          validQ[s][w] <= 1'b0;
    end else if (strb.wrEn && strb.alloc) begin
      validQ[updIdx][wrWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      ctrQ[updIdx][wrWay] <= strb.ctrNew;
      if (strb.alloc)     tagQ[updIdx][wrWay]    <= updTag;
      if (strb.setTarget) targetQ[updIdx][wrWay] <= updTarget;
    end
  end

  AST_ONE_HIT_WAY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookHitVec)); // R5

  AST_ALLOC_WEAK_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.alloc) |=>
      (validQ[$past(updIdx)][$past(wrWay)] && ctrQ[$past(updIdx)][$past(wrWay)] == CTR_WEAK_TAKEN)); // R6

endmodule

// File: rtl/btbControl.sv
module btbControl
  import btbPkg::*;
#(
  parameter int PC_W    = 32,
  parameter int WAYS    = 4,
  parameter int SETS    = 64,
  parameter int IDX_LSB = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  input  logic [PC_W-1:0]  updPc,
  input  logic             updTaken,
  input  logic [WAYS-1:0]  updHitVec,
  input  logic [CTR_W-1:0] updHitCtr,
  input  logic [WAYS-1:0]  updValidVec,
  output btbStrobe_t       strb,
  output logic [1:0]       resCase
);

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // per-set recency: age 0 is most recent, WAYS-1 least recent
  logic [WAY_W-1:0] ageQ [SETS][WAYS];

  logic [IDX_W-1:0] updIdx;
  logic             hitAny;
  logic [WAY_W-1:0] hitWay, victimWay, selWay, touchedAge;
  logic             freeFound;
  logic [CTR_W-1:0] ctrStep;
  resCase_e         caseNow;

  assign updIdx = updPc[IDX_LSB +: IDX_W];
  assign hitAny = |updHitVec;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (updHitVec[w]) hitWay = WAY_W'(w);
  end

  // lowest invalid way first, otherwise the oldest
  always_comb begin
    victimWay = '0;
    freeFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!updValidVec[w] && !freeFound) begin
        victimWay = WAY_W'(w);
        freeFound = 1'b1;
      end
    end
    if (!freeFound) begin
      for (int w = 0; w < WAYS; w++)
        if (ageQ[updIdx][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
    end
  end

  assign selWay     = hitAny ? hitWay : victimWay;
  assign touchedAge = ageQ[updIdx][selWay];

  always_comb begin
    if (updTaken)
      ctrStep = (updHitCtr == CTR_MAX) ? updHitCtr : updHitCtr + CTR_W'(1);
    else
      ctrStep = (updHitCtr == '0) ? updHitCtr : updHitCtr - CTR_W'(1);
  end

  always_comb begin
    strb           = '0;
    strb.wrEn      = updValid && (hitAny || updTaken);
    strb.alloc     = updValid && !hitAny && updTaken;
    strb.setTarget = updTaken;
    strb.way       = WAY_FIELD_W'(selWay);
    strb.ctrNew    = hitAny ? ctrStep : CTR_WEAK_TAKEN;
  end

  always_comb begin
    if (hitAny)
      caseNow = (updHitCtr[CTR_W-1] == updTaken) ? CASE_PRED_OK : CASE_PRED_BAD;
    else
      caseNow = updTaken ? CASE_DFLT_BAD : CASE_DFLT_OK;
  end
  assign resCase = caseNow;

  // recency update on every write to the table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ageQ[s][w] <= WAY_W'(w);
    end else if (strb.wrEn) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == selWay)
          ageQ[updIdx][w] <= '0;
        else if (ageQ[updIdx][w] < touchedAge)
          ageQ[updIdx][w] <= ageQ[updIdx][w] + WAY_W'(1);
      end
    end
  end

  AST_MRU_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (ageQ[$past(updIdx)][$past(selWay)] == '0)); // R8

  AST_NO_WRITE_ON_NT_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && resCase == 2'd2) |-> !strb.wrEn); // R6

endmodule

// File: rtl/btbPredictor.sv
module btbPredictor
  import btbPkg::*;
#(
  parameter int PC_W       = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int INST_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predHit,
  output logic            predTaken,
  output logic [PC_W-1:0] nextPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  output logic [1:0]      resCase
);

  localparam int IDX_LSB = $clog2(INST_BYTES);

  btbStrobe_t       strb;
  logic             lookHit;
  logic [CTR_W-1:0] lookCtr;
  logic [PC_W-1:0]  lookTarget;
  logic [WAYS-1:0]  updHitVec, updValidVec;
  logic [CTR_W-1:0] updHitCtr;

  btbDatapath #(.PC_W(PC_W), .WAYS(WAYS), .SETS(SETS), .IDX_LSB(IDX_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .updPc(updPc), .updTarget(updTarget),
    .strb(strb), .lookHit(lookHit), .lookCtr(lookCtr), .lookTarget(lookTarget),
    .updHitVec(updHitVec), .updHitCtr(updHitCtr), .updValidVec(updValidVec)
  );

  btbControl #(.PC_W(PC_W), .WAYS(WAYS), .SETS(SETS), .IDX_LSB(IDX_LSB)) u_ctl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updHitVec(updHitVec), .updHitCtr(updHitCtr), .updValidVec(updValidVec),
    .strb(strb), .resCase(resCase)
  );

  assign predHit   = lookHit;
  assign predTaken = lookHit && lookCtr[CTR_W-1];
  assign nextPc    = predTaken ? lookTarget : fetchPc + PC_W'(INST_BYTES);

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> predHit); // R3

endmodule

// File: tb/btbPredictor_tb.sv
`timescale 1ns/1ps
module btbPredictor_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predHit, predTaken;
  logic [31:0] nextPc;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;
  logic [1:0]  resCase;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  btbPredictor u_dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predHit(predHit), .predTaken(predTaken),
    .nextPc(nextPc), .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updTarget(updTarget), .resCase(resCase)
  );

  // reference table, recency kept as write timestamps
  bit          mValid [64][4];
  int unsigned mTag   [64][4];
  logic [31:0] mTarget[64][4];
  int          mCtr   [64][4];
  longint      mStamp [64][4];
  longint      stampNow = 0;

  function automatic int idxOf(logic [31:0] pc); return int'(pc[7:2]); endfunction
  function automatic int unsigned tagOf(logic [31:0] pc); return int'(pc[31:8]); endfunction

  function automatic int findWay(logic [31:0] pc);
    for (int w = 0; w < 4; w++)
      if (mValid[idxOf(pc)][w] && mTag[idxOf(pc)][w] == tagOf(pc)) return w;
    return -1;
  endfunction

  function automatic int expCase(logic [31:0] pc, bit tk);
    int w = findWay(pc);
    if (w >= 0) return ((mCtr[idxOf(pc)][w] >= 2) == tk) ? 0 : 1;
    return tk ? 3 : 2;
  endfunction

  function automatic void modelUpdate(logic [31:0] pc, bit tk, logic [31:0] tgt);
    int s = idxOf(pc);
    int w = findWay(pc);
    stampNow++;
    if (w >= 0) begin
      if (tk && mCtr[s][w] < 3) mCtr[s][w]++;
      if (!tk && mCtr[s][w] > 0) mCtr[s][w]--;
      if (tk) mTarget[s][w] = tgt;
      mStamp[s][w] = stampNow;
    end else if (tk) begin
      int v = -1;
      for (int k = 0; k < 4; k++) if (!mValid[s][k] && v < 0) v = k;
      if (v < 0) begin
        v = 0;
        for (int k = 1; k < 4; k++) if (mStamp[s][k] < mStamp[s][v]) v = k;
      end
      mValid[s][v] = 1'b1; mTag[s][v] = tagOf(pc); mTarget[s][v] = tgt;
      mCtr[s][v] = 2; mStamp[s][v] = stampNow;
    end
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one cycle, check combinational outputs, advance the model
  task automatic step(logic [31:0] fpc, bit uv, logic [31:0] upc, bit tk,
                      logic [31:0] tgt, string req);
    int w;
    bit eHit, eTk;
    logic [31:0] eNext;
    fetchPc = fpc; updValid = uv; updPc = upc; updTaken = tk; updTarget = tgt;
    #1;
    w = findWay(fpc);
    eHit = (w >= 0);
    eTk = eHit && mCtr[idxOf(fpc)][w] >= 2;
    eNext = eTk ? mTarget[idxOf(fpc)][w] : fpc + 32'd4;
    check(predHit == eHit, req, "predHit", 32'(predHit), 32'(eHit));
    check(predTaken == eTk, req, "predTaken", 32'(predTaken), 32'(eTk));
    check(nextPc == eNext, req, "nextPc", nextPc, eNext);
    if (uv) begin
      check(int'(resCase) == expCase(upc, tk), "R9", "resCase", 32'(resCase),
            32'(expCase(upc, tk)));
      modelUpdate(upc, tk, tgt);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 4; w++) begin
        mValid[s][w] = 0; mCtr[s][w] = 0; mStamp[s][w] = 0; mTag[s][w] = 0; mTarget[s][w] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: clean table after reset
    step(32'h0000_1014, 0, 0, 0, 0, "R1");
    step(32'h0000_2014, 0, 0, 0, 0, "R1");
    // R2 / R6: not-taken miss allocates nothing
    step(32'h0000_1014, 1, 32'h0000_1014, 0, 32'h0000_8000, "R6");
    step(32'h0000_1014, 0, 0, 0, 0, "R2");
    // R10: same-cycle lookup sees old state while allocating
    step(32'h0000_1014, 1, 32'h0000_1014, 1, 32'h0000_8000, "R10");
    // R3: allocated entry is weakly taken
    step(32'h0000_1014, 0, 0, 0, 0, "R3");
    // R4 / R7: counter walks down and saturates at zero
    step(32'h0000_1014, 1, 32'h0000_1014, 0, 0, "R7");
    step(32'h0000_1014, 0, 0, 0, 0, "R4");
    step(32'h0000_1014, 1, 32'h0000_1014, 0, 0, "R7");
    step(32'h0000_1014, 1, 32'h0000_1014, 0, 0, "R7");
    step(32'h0000_1014, 1, 32'h0000_1014, 1, 32'h0000_8000, "R7");
    step(32'h0000_1014, 0, 0, 0, 0, "R4");
    step(32'h0000_1014, 1, 32'h0000_1014, 1, 32'h0000_8000, "R7");
    step(32'h0000_1014, 1, 32'h0000_1014, 1, 32'h0000_8000, "R7");
    step(32'h0000_1014, 1, 32'h0000_1014, 1, 32'h0000_8000, "R7");
    step(32'h0000_1014, 0, 0, 0, 0, "R3");
    // R5: fill a set with four tags
    step(32'h0000_1014, 1, 32'h0000_2014, 1, 32'h0000_A000, "R5");
    step(32'h0000_2014, 1, 32'h0000_3014, 1, 32'h0000_B000, "R5");
    step(32'h0000_3014, 1, 32'h0000_4014, 1, 32'h0000_C000, "R5");
    step(32'h0000_4014, 0, 0, 0, 0, "R5");
    step(32'h0000_1018, 0, 0, 0, 0, "R5");
    // R8: touch the oldest, then evict the next oldest
    step(32'h0000_1014, 1, 32'h0000_1014, 1, 32'h0000_8000, "R8");
    step(32'h0000_1014, 1, 32'h0000_5014, 1, 32'h0000_D000, "R8");
    step(32'h0000_2014, 0, 0, 0, 0, "R8");
    step(32'h0000_1014, 0, 0, 0, 0, "R8");
    step(32'h0000_5014, 0, 0, 0, 0, "R8");
    // R7: taken update refreshes the target
    step(32'h0000_3014, 1, 32'h0000_3014, 1, 32'h9999_0000, "R7");
    step(32'h0000_3014, 0, 0, 0, 0, "R7");

    // random traffic on three crowded sets, six tags each
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] fp, up, tg;
      bit uv, tk;
      fp = {24'($urandom_range(0, 5)), 6'($urandom_range(0, 2)), 2'b00};
      up = {24'($urandom_range(0, 5)), 6'($urandom_range(0, 2)), 2'b00};
      if ($urandom_range(0, 3) == 0) up = fp;
      tg = {$urandom} & 32'hFFFF_FFFC;
      uv = ($urandom_range(0, 2) != 0);
      tk = ($urandom_range(0, 9) < 6);
      step(fp, uv, up, tk, tg, "R8");
    end

    // reset again, table must be empty (R1)
    rstN = 1'b0;
    updValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 4; w++) mValid[s][w] = 0;
    step(32'h0000_1014, 0, 0, 0, 0, "R1");
    step(32'h0000_0004, 0, 0, 0, 0, "R1");

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule